// File: doc/BRIEF.md
# Half-Bridge Gate Timer with Blanked Phase Check

This block times the two gate enables of a half-bridge. A half-cycle length, given in clock cycles, sets the switching period. Every half-cycle begins with a fixed interval in which both gates are off, followed by the on-time of one gate. The gates take turns, and the low-side gate always conducts first after the bridge is enabled. That way the high-side bootstrap supply is charged before the high side switches for the first time.

While the low side conducts, a ramp counts cycles from the rising edge of the low-side gate. When the ramp reaches a threshold word, it marks a reference phase. Because the reference is a count inside the half-cycle, it does not depend on the switching frequency. The digitised load-current zero-crossing comparator is ignored for a fixed window after each low-side turn-on, which rejects switching noise. After that window, the first crossing is latched. The block drives a phase-error output for every cycle in which the reference and the latched crossing disagree, and a sign output tells whether the crossing came late or early.

The timing constants are given in nanoseconds together with the clock frequency, and the block converts them to cycle counts.

Top module: `hb_phase_timer`

## Requirements
- R1: While `bridge_en` is low, and from the first clock edge at which it is sampled low, `ho`, `lo` and `perr` are all low. The same holds during reset.
- R2: After `bridge_en` is sampled high from the idle state, `lo` goes high after exactly DEAD_CYC cycles of both outputs low, and `ho` does not go high before that first `lo` pulse.
- R3: `ho` and `lo` are never high in the same cycle.
- R4: Between one output falling and the other rising, both outputs are low for exactly DEAD_CYC cycles. DEAD_CYC is DEAD_NS times the clock rate, and the default is 2000 ns, or 100 cycles at 50 MHz.
- R5: With `half_period` = H > DEAD_CYC, each of `lo` and `ho` stays high for H − DEAD_CYC cycles, so a full period lasts 2·H cycles.
- R6: A change of `half_period` affects neither the dead time nor the on-time already in progress. The value is captured when each dead interval begins, and it applies to the on-time that follows that interval.
- R7: With `half_period` ≤ DEAD_CYC, each on-time is exactly one cycle.
- R8: Cycle index k counts from 0 at the first cycle with `lo` high. A `zc_in` high in a cycle with k < BLANK_CYC is ignored. BLANK_CYC is 400 ns, or 20 cycles at 50 MHz. A `zc_in` high at k ≥ BLANK_CYC latches a crossing that is seen from cycle k+1.
- R9: The reference is active in the `lo` cycles with k ≥ `ref_thresh`. With no crossing latched, `perr` is high in exactly those cycles, and `perr_late` = 1 there, meaning the crossing is late.
- R10: A crossing latched at cycle c+1 < `ref_thresh` drives `perr` high in cycles c+1 … `ref_thresh`−1, with `perr_late` = 0 (early). `perr` is low after that.
- R11: A crossing latched at cycle c+1 > `ref_thresh` drives `perr` high in cycles `ref_thresh` … c, with `perr_late` = 1.
- R12: `perr` is low whenever `lo` is low, and a crossing latched in one low-side pulse never carries into the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bridge_en | input | 1 | Runs the bridge when high |
| half_period | input | PW | Half-cycle length in clock cycles, dead time included |
| ref_thresh | input | PW | Reference phase as a cycle count from the low-side rising edge |
| zc_in | input | 1 | Digitised zero-crossing comparator |
| ho | output | 1 | High-side gate enable |
| lo | output | 1 | Low-side gate enable |
| perr | output | 1 | High while the reference and the measured crossing disagree |
| perr_late | output | 1 | Sign of `perr`: 1 means the crossing is later than the reference |

## Verification
The hardest situation to reach from the ports is a comparator edge placed at a chosen cycle inside the low-side pulse. This matters most right at the edge of the blanking window, and on either side of the reference threshold. The stimulus uses the falling edge at which `lo` is first seen high as index 0. It counts falling edges from there and raises `zc_in` for one cycle at the target index, for example 19 and 20 for the blanking boundary. It then compares `perr` and `perr_late` cycle by cycle against what the requirements predict.

// File: rtl/hbt_pkg.sv
package hbt_pkg;

    // Bridge sequencing states; each half-cycle is a gap followed by a drive.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_GAP_LO   = 3'd1,
        ST_DRIVE_LO = 3'd2,
        ST_GAP_HO   = 3'd3,
        ST_DRIVE_HO = 3'd4
    } bridge_state_t;

    function automatic int ns_to_cycles(input int ns, input int clk_mhz);
        return (ns * clk_mhz) / 1000;
    endfunction

endpackage

// File: rtl/hbt_sequencer.sv
module hbt_sequencer
    import hbt_pkg::*;
#(
    parameter int PW       = 16,
    parameter int DEAD_CYC = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] half_period,
    output logic          ho,
    output logic          lo
);

    localparam logic [PW-1:0] DEAD_W = PW'(DEAD_CYC);

    bridge_state_t state_q, state_d;
    logic [PW-1:0] cnt_q;
    logic [PW-1:0] per_q;
    logic [PW-1:0] on_len;
    logic          expire;

    assign expire = (cnt_q == '0);
    // On-time of the half-cycle whose period was captured at the gap entry.
    assign on_len = (per_q > DEAD_W) ? (per_q - DEAD_W) : PW'(1);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!run) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_GAP_LO;
                ST_GAP_LO:   if (expire) state_d = ST_DRIVE_LO;
                ST_DRIVE_LO: if (expire) state_d = ST_GAP_HO;
                ST_GAP_HO:   if (expire) state_d = ST_DRIVE_HO;
                ST_DRIVE_HO: if (expire) state_d = ST_GAP_LO;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Interval counter and period capture at each half-cycle boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            per_q <= '0;
        end else if (state_d != state_q) begin
            unique case (state_d)
                ST_GAP_LO, ST_GAP_HO: begin
                    cnt_q <= DEAD_W - PW'(1);
                    per_q <= half_period;
                end
                ST_DRIVE_LO, ST_DRIVE_HO: cnt_q <= on_len - PW'(1);
                default:                  cnt_q <= '0;
            endcase
        end else if (!expire) begin
            cnt_q <= cnt_q - PW'(1);
        end
    end

    // Outputs decoded from the registered state
    always_comb begin
        ho = 1'b0;
        lo = 1'b0;
        unique case (state_q)
            ST_DRIVE_LO: lo = 1'b1;
            ST_DRIVE_HO: ho = 1'b1;
            default: begin
                ho = 1'b0;
                lo = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/hbt_blank_ramp.sv
module hbt_blank_ramp #(
    parameter int PW        = 16,
    parameter int BLANK_CYC = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lo,
    output logic [PW-1:0] ramp,
    output logic          sense_open
);

    // Ramp counts cycles since the low-side rising edge, saturating.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             ramp <= '0;
        else if (!lo)           ramp <= '0;
        else if (ramp != '1)    ramp <= ramp + PW'(1);
    end

    generate
        if (BLANK_CYC == 0) begin : g_no_blank
            assign sense_open = lo;
        end else begin : g_blank
            assign sense_open = lo && (ramp >= PW'(BLANK_CYC));
        end
    endgenerate

endmodule

// File: rtl/hbt_phase_cmp.sv
module hbt_phase_cmp #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lo,
    input  logic          sense_open,
    input  logic          zc_in,
    input  logic [PW-1:0] ramp,
    input  logic [PW-1:0] ref_thresh,
    output logic          zc_seen,
    output logic          perr,
    output logic          perr_late
);

    logic ref_act;

    // Latched crossing, cleared whenever the low side is off.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       zc_seen <= 1'b0;
        else if (!lo)                     zc_seen <= 1'b0;
        else if (sense_open && zc_in)     zc_seen <= 1'b1;
    end

    assign ref_act   = lo && (ramp >= ref_thresh);
    assign perr      = lo && (ref_act != zc_seen);
    assign perr_late = lo && ref_act && !zc_seen;

endmodule

// File: rtl/hb_phase_timer.sv
module hb_phase_timer
    import hbt_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int DEAD_NS  = 2000,
    parameter int BLANK_NS = 400,
    parameter int PW       = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bridge_en,
    input  logic [PW-1:0] half_period,
    input  logic [PW-1:0] ref_thresh,
    input  logic          zc_in,
    output logic          ho,
    output logic          lo,
    output logic          perr,
    output logic          perr_late
);

    localparam int CLK_MHZ   = CLK_HZ / 1_000_000;
    localparam int DEAD_RAW  = ns_to_cycles(DEAD_NS, CLK_MHZ);
    localparam int DEAD_CYC  = (DEAD_RAW < 1) ? 1 : DEAD_RAW;
    localparam int BLANK_CYC = ns_to_cycles(BLANK_NS, CLK_MHZ);

    logic [PW-1:0] ramp;
    logic          sense_open;
    logic          zc_seen;

    hbt_sequencer #(.PW(PW), .DEAD_CYC(DEAD_CYC)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (bridge_en),
        .half_period (half_period),
        .ho          (ho),
        .lo          (lo)
    );

    hbt_blank_ramp #(.PW(PW), .BLANK_CYC(BLANK_CYC)) u_ramp (
        .clk        (clk),
        .rst_n      (rst_n),
        .lo         (lo),
        .ramp       (ramp),
        .sense_open (sense_open)
    );

    hbt_phase_cmp #(.PW(PW)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .lo         (lo),
        .sense_open (sense_open),
        .zc_in      (zc_in),
        .ramp       (ramp),
        .ref_thresh (ref_thresh),
        .zc_seen    (zc_seen),
        .perr       (perr),
        .perr_late  (perr_late)
    );

endmodule

// File: rtl/hbt_checker.sv
module hbt_checker #(
    parameter int DEAD_CYC  = 100,
    parameter int BLANK_CYC = 20
) (
    input logic clk,
    input logic rst_n,
    input logic bridge_en,
    input logic ho,
    input logic lo,
    input logic perr,
    input logic zc_latched
);

    int  gap_q;
    int  lo_age_q;
    logic lo_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q     <= 0;
            lo_age_q  <= 0;
            lo_seen_q <= 1'b0;
        end else begin
            if (ho || lo)                gap_q <= 0;
            else if (gap_q < 1_000_000)  gap_q <= gap_q + 1;
            if (!lo)                        lo_age_q <= 0;
            else if (lo_age_q < 1_000_000)  lo_age_q <= lo_age_q + 1;
            if (!bridge_en) lo_seen_q <= 1'b0;
            else if (lo)    lo_seen_q <= 1'b1;
        end
    end

    assert_off_when_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bridge_en |=> (!ho && !lo && !perr));

    assert_lo_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ho |-> lo_seen_q);

    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ho && lo));

    assert_dead_before_ho_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ho) |-> (gap_q >= DEAD_CYC));

    assert_dead_before_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo) |-> (gap_q >= DEAD_CYC));

    assert_blank_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lo && (lo_age_q <= BLANK_CYC)) |-> !zc_latched);

    assert_err_in_lo_R12: assert property (@(posedge clk) disable iff (!rst_n)
        perr |-> lo);

endmodule

bind hb_phase_timer hbt_checker #(.DEAD_CYC(DEAD_CYC), .BLANK_CYC(BLANK_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bridge_en  (bridge_en),
    .ho         (ho),
    .lo         (lo),
    .perr       (perr),
    .zc_latched (zc_seen)
);

// File: tb/sim_hb_phase_timer.sv
module sim_hb_phase_timer;

    localparam int CLK_PERIOD_NS = 20;
    localparam int PW    = 16;
    localparam int DEAD  = 100;
    localparam int BLANK = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bridge_en = 1'b0;
    logic [PW-1:0] half_period = 16'd300;
    logic [PW-1:0] ref_thresh = 16'd100;
    logic          zc_in = 1'b0;
    logic          ho, lo, perr, perr_late;

    int n_checks = 0;
    int n_fail   = 0;
    int overlap_cnt = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD_NS/2) clk = ~clk;

    hb_phase_timer u0 (
        .clk(clk), .rst_n(rst_n), .bridge_en(bridge_en),
        .half_period(half_period), .ref_thresh(ref_thresh), .zc_in(zc_in),
        .ho(ho), .lo(lo), .perr(perr), .perr_late(perr_late)
    );

    always @(negedge clk) if (ho && lo) overlap_cnt++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic to_lo_rise();
        @(negedge clk);
        while (lo) @(negedge clk);
        while (!lo) @(negedge clk);
    endtask

    task automatic measure(output int lo_n, output int g1, output int ho_n, output int g2);
        to_lo_rise();
        lo_n = 0; g1 = 0; ho_n = 0; g2 = 0;
        while (lo) begin lo_n++; @(negedge clk); end
        while (!ho && !lo) begin g1++; @(negedge clk); end
        while (ho) begin ho_n++; @(negedge clk); end
        while (!ho && !lo) begin g2++; @(negedge clk); end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!ho && !lo && !perr, "R1 reset", {ho, lo, perr}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(!ho && !lo && !perr, "R1 idle", {ho, lo, perr}, 0);
    endtask

    task automatic t_first_lo();
        int low_n = 0;
        bit ho_early = 1'b0;
        half_period = 16'd300;
        bridge_en = 1'b1;
        @(negedge clk);
        while (!lo) begin
            if (ho) ho_early = 1'b1;
            low_n++;
            @(negedge clk);
        end
        check(low_n == DEAD, "R2 first lo delay", low_n, DEAD);
        check(!ho_early, "R2 ho before lo", ho_early, 0);
    endtask

    task automatic t_steady();
        int a, b, c, d;
        measure(a, b, c, d);
        check(a == 200, "R5 lo on-time", a, 200);
        check(c == 200, "R5 ho on-time", c, 200);
        check(b == DEAD, "R4 dead lo->ho", b, DEAD);
        check(d == DEAD, "R4 dead ho->lo", d, DEAD);
    endtask

    task automatic t_period_change();
        int n = 0, g = 0, h = 0;
        half_period = 16'd300;
        to_lo_rise();
        half_period = 16'd200;
        while (lo) begin n++; @(negedge clk); end
        while (!ho && !lo) begin g++; @(negedge clk); end
        while (ho) begin h++; @(negedge clk); end
        check(n == 200, "R6 running lo keeps old period", n, 200);
        check(g == DEAD, "R6 dead unchanged", g, DEAD);
        check(h == 100, "R6 next ho uses new period", h, 100);
    endtask

    task automatic t_short();
        int a, b, c, d;
        half_period = 16'd50;
        measure(a, b, c, d);
        measure(a, b, c, d);
        check(a == 1, "R7 short lo", a, 1);
        check(c == 1, "R7 short ho", c, 1);
        check(b == DEAD && d == DEAD, "R7 short dead", b, DEAD);
        half_period = 16'd300;
        measure(a, b, c, d);
    endtask

    task automatic t_disable();
        int low_n = 0;
        @(negedge clk);
        while (!ho) @(negedge clk);
        repeat (3) @(negedge clk);
        bridge_en = 1'b0;
        @(negedge clk);
        check(!ho && !lo, "R1 disable mid-pulse", {ho, lo}, 0);
        repeat (20) begin
            @(negedge clk);
            if (ho || lo || perr) low_n++;
        end
        check(low_n == 0, "R1 stays off", low_n, 0);
        bridge_en = 1'b1;
        low_n = 0;
        @(negedge clk);
        while (!lo && !ho) begin low_n++; @(negedge clk); end
        check(lo && low_n == DEAD, "R2 restart with lo", low_n, DEAD);
    endtask

    // m: cycle index at which zc_in is pulsed; thr: reference threshold
    task automatic phase_run(input int m, input int thr, input string req);
        int j = 0, bad = 0, first_bad = -1, stray = 0;
        bit exp_fb, exp_ref, exp_e, exp_l;
        ref_thresh = PW'(thr);
        to_lo_rise();
        while (lo) begin
            exp_fb  = (m >= BLANK) && (j > m);
            exp_ref = (j >= thr);
            exp_e   = exp_ref ^ exp_fb;
            exp_l   = exp_ref && !exp_fb;
            if (perr !== exp_e || perr_late !== exp_l) begin
                bad++;
                if (first_bad < 0) first_bad = j;
            end
            zc_in = (j == m);
            j++;
            @(negedge clk);
        end
        zc_in = 1'b0;
        check(bad == 0, req, first_bad, -1);
        repeat (150) begin
            if (perr && !lo) stray++;
            @(negedge clk);
        end
        check(stray == 0, "R12 perr outside lo", stray, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        t_reset();
        t_first_lo();
        t_steady();
        t_period_change();
        t_short();
        t_disable();
        phase_run(5,   100, "R8 crossing inside blank ignored");
        phase_run(19,  100, "R8 crossing at last blanked cycle ignored");
        phase_run(20,  100, "R8 crossing at first open cycle taken");
        phase_run(400, 100, "R9 no crossing, late sign");
        phase_run(40,  100, "R10 early crossing");
        phase_run(150, 100, "R11 late crossing");
        phase_run(60,  30,  "R11 late crossing, low threshold");
        check(overlap_cnt == 0, "R3 overlap cycles", overlap_cnt, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule